// File: doc/BRIEF.md
# Output-Compare Timer with Stream Compare Reload

The block is a counting timer with one output-compare channel. A prescaler slows the timer clock down. The counter runs up, down or up-and-down against a programmable reload limit. Each time the counter reaches the compare value, a compare event fires. The event sets a sticky flag, changes the output pin according to the selected output mode, and, when reloading is enabled, asks an external transfer engine for the next compare value. Feeding a table of compare values through that request lets the pin produce an arbitrary edge sequence, such as a waveform of toggles at programmed instants, without any processor work per edge.

The compare value enters through a valid/ready stream port. The timer is the consumer, and `cmp_ready` is the reload request. Back-pressure works like this:
- `cmp_ready` rises one cycle after a compare event and stays high until a transfer takes place (`cmp_valid` and `cmp_ready` both high at a clock edge).
- `cmp_valid` offered while `cmp_ready` is low transfers nothing.
- The producer may hold `cmp_valid` high for any number of cycles until the transfer.

A compare value larger than the reload limit can never be matched. In that case the event is still produced once per counting period, at the wrap of the counter. A circular feeder therefore keeps being drained even when no visible edge results.

A one-pulse option starts the counter from a rising trigger edge and stops it at the next wrap. Compare writes from either source can take effect at once or be held in a shadow register until the next wrap.

Top module: `oc_timer`

## Requirements
- R1: While running, the counter takes one step every `cfg_psc`+1 clock cycles; while stopped, the counter and the prescale phase hold and reset respectively.
- R2: Direction code 00 counts up from 0 to `cfg_reload`, then wraps to 0 (overflow). Code 01 counts down from `cfg_reload` to 0, then wraps to `cfg_reload` (underflow). Code 10 counts up to `cfg_reload`, turns down (overflow), reaches 0 and turns up (underflow). The count starts at 0 after reset.
- R3: A compare event fires on the step that brings the counter to the active compare value.
- R4: When the active compare value exceeds `cfg_reload`, the event fires at each wrap instead: at overflow for direction codes 00 and 10, at underflow for code 01. This gives one event per period.
- R5: The output modes are selected by mode code:
  - 000 holds the reference level.
  - 011 inverts the reference on each event.
  - 110 drives the reference to 1 while the counter is below the compare value and to 0 otherwise.
  - 111 is the inverse of 110.
  - Any other code holds.

  `oc_pin` equals the reference XOR `cfg_pol`.
- R6: `cmp_flag` is set by an event and cleared by a `flag_clr` pulse. An event in the same cycle as a clear leaves the flag set.
- R7: With `cfg_dma_en` high, an event raises `cmp_ready` on the next cycle. It stays high until a transfer. An event while a request is already pending yields one request only. An event in the transfer cycle keeps the request high. With `cfg_dma_en` low, `cmp_ready` drops and no request is raised. `cmp_valid` while `cmp_ready` is low has no effect.
- R8: With `cfg_preload` low, a written compare value becomes active at the edge of the write. With `cfg_preload` high, it goes to a shadow register and becomes active at the next overflow or underflow.
- R9: With `cfg_one_pulse` high, `cfg_enable` is ignored. A rising edge on `trig_in` starts the counter, and the next overflow or underflow stops it. If both happen in one cycle, the stop wins.
- R10: When a stream transfer and a software write (`sw_cmp_we`) happen in the same cycle, the stream value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run control in free-running operation |
| cfg_one_pulse | input | 1 | Trigger-started single-period operation |
| trig_in | input | 1 | Start trigger, rising edge used |
| cfg_dir | input | 2 | Count direction code |
| cfg_mode | input | 3 | Output mode code |
| cfg_pol | input | 1 | Pin polarity inversion |
| cfg_preload | input | 1 | Hold compare writes until the next wrap |
| cfg_dma_en | input | 1 | Enable reload requests on events |
| cfg_psc | input | PSC_W | Prescale divider minus one |
| cfg_reload | input | CNT_W | Reload limit |
| sw_cmp_we | input | 1 | Software compare write strobe |
| sw_cmp_data | input | CNT_W | Software compare write value |
| flag_clr | input | 1 | Clear pulse for the compare flag |
| cmp_valid | input | 1 | Stream: compare value offered |
| cmp_data | input | CNT_W | Stream: compare value |
| cmp_ready | output | 1 | Stream: reload request, value accepted |
| count | output | CNT_W | Current counter value |
| running | output | 1 | Counter enabled |
| cmp_flag | output | 1 | Sticky compare flag |
| oc_pin | output | 1 | Compare output pin |

## Verification
The main target is a compare value above the reload limit in each of the three directions. A design that only matched on equality would stall the feeder and freeze the pin. A design that used the wrong wrap in center mode would fire twice per period.

The bench also goes after the following single-cycle cases:
- An event landing on the transfer cycle. A wrong design would lose a request.
- An event coinciding with a flag clear. A wrong design would drop the flag.
- A stream transfer racing a software write. A wrong design would keep the software value.
- Offers made while no request is pending. A wrong design would load a stray value.

Preloaded writes are checked to take effect only at the wrap. One-pulse operation is checked to stop after exactly one period, so a design that kept counting would toggle the pin again.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  localparam logic [1:0] DIR_UP     = 2'b00;
  localparam logic [1:0] DIR_DOWN   = 2'b01;
  localparam logic [1:0] DIR_CENTER = 2'b10;

  localparam logic [2:0] MODE_FROZEN = 3'b000;
  localparam logic [2:0] MODE_TOGGLE = 3'b011;
  localparam logic [2:0] MODE_PWM_LO = 3'b110;
  localparam logic [2:0] MODE_PWM_HI = 3'b111;

  typedef struct packed {
    logic tick;
    logic ovf;
    logic udf;
  } tb_evt_t;

endpackage

// File: rtl/oc_timebase.sv
module oc_timebase
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             one_pulse,
  input  logic             trig,
  input  logic [1:0]       dir,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] reload,
  output logic             running,
  output logic [CNT_W-1:0] cnt_cur,
  output logic [CNT_W-1:0] cnt_nxt,
  output tb_evt_t          evt
);

  logic [PSC_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, trig_q, falling_q;
  logic             fall_nxt, tick_c, ovf_c, udf_c, trig_rise;

  assign tick_c    = run_q && (div_q == psc);
  assign trig_rise = trig && !trig_q;

  always_comb begin
    cnt_nxt  = cnt_q;
    fall_nxt = falling_q;
    ovf_c    = 1'b0;
    udf_c    = 1'b0;
    if (tick_c) begin
      case (dir)
        DIR_DOWN: begin
          if (cnt_q == '0) begin
            cnt_nxt = reload;
            udf_c   = 1'b1;
          end else begin
            cnt_nxt = cnt_q - 1'b1;
          end
        end
        DIR_CENTER: begin
          if (!falling_q) begin
            if (cnt_q == reload) begin
              cnt_nxt  = reload - 1'b1;
              fall_nxt = 1'b1;
              ovf_c    = 1'b1;
            end else begin
              cnt_nxt = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_nxt  = CNT_W'(1);
              fall_nxt = 1'b0;
              udf_c    = 1'b1;
            end else begin
              cnt_nxt = cnt_q - 1'b1;
            end
          end
        end
        default: begin
          if (cnt_q == reload) begin
            cnt_nxt = '0;
            ovf_c   = 1'b1;
          end else begin
            cnt_nxt = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      cnt_q     <= '0;
      run_q     <= 1'b0;
      trig_q    <= 1'b0;
      falling_q <= 1'b0;
    end else begin
      trig_q    <= trig;
      div_q     <= (!run_q || tick_c) ? '0 : div_q + 1'b1;
      cnt_q     <= cnt_nxt;
      falling_q <= fall_nxt;
      if (one_pulse) begin
        if (ovf_c || udf_c) run_q <= 1'b0;
        else if (trig_rise) run_q <= 1'b1;
      end else begin
        run_q <= enable;
      end
    end
  end

  assign running  = run_q;
  assign cnt_cur  = cnt_q;
  assign evt.tick = tick_c;
  assign evt.ovf  = ovf_c;
  assign evt.udf  = udf_c;

endmodule

// File: rtl/oc_ccr_store.sv
module oc_ccr_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preload,
  input  logic             dma_en,
  input  logic             wrap,
  input  logic             cmp_evt,
  input  logic             sw_we,
  input  logic [CNT_W-1:0] sw_data,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] in_data,
  output logic             in_ready,
  output logic [CNT_W-1:0] ccr
);

  logic [CNT_W-1:0] shadow_q, active_q, shadow_nxt, wr_val;
  logic             req_q, xfer, wr_en;

  assign xfer       = in_valid && req_q;
  assign wr_en      = xfer || sw_we;
  assign wr_val     = xfer ? in_data : sw_data;
  assign shadow_nxt = wr_en ? wr_val : shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      req_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_nxt;
      if (!preload && wr_en)    active_q <= wr_val;
      else if (preload && wrap) active_q <= shadow_nxt;
      req_q <= dma_en && (cmp_evt || (req_q && !xfer));
    end
  end

  assign in_ready = req_q;
  assign ccr      = active_q;

endmodule

// File: rtl/oc_out_unit.sv
module oc_out_unit
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tb_evt_t          evt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [1:0]       dir,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] ccr,
  input  logic [2:0]       mode,
  input  logic             pol,
  input  logic             flag_clr,
  output logic             cmp_evt,
  output logic             flag,
  output logic             pin
);

  logic ref_q, flag_q, beyond, wrap_hit, below;

  assign beyond   = ccr > reload;
  assign wrap_hit = (dir == DIR_CENTER) ? evt.ovf : (evt.ovf || evt.udf);
  assign cmp_evt  = evt.tick && ((cnt_nxt == ccr) || (beyond && wrap_hit));
  assign below    = cnt_nxt < ccr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cmp_evt)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      case (mode)
        MODE_TOGGLE: ref_q <= ref_q ^ cmp_evt;
        MODE_PWM_LO: ref_q <= below;
        MODE_PWM_HI: ref_q <= !below;
        default:     ref_q <= ref_q;
      endcase
    end
  end

  assign flag = flag_q;
  assign pin  = ref_q ^ pol;

endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_one_pulse,
  input  logic             trig_in,
  input  logic [1:0]       cfg_dir,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_pol,
  input  logic             cfg_preload,
  input  logic             cfg_dma_en,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             sw_cmp_we,
  input  logic [CNT_W-1:0] sw_cmp_data,
  input  logic             flag_clr,
  input  logic             cmp_valid,
  input  logic [CNT_W-1:0] cmp_data,
  output logic             cmp_ready,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             cmp_flag,
  output logic             oc_pin
);

  tb_evt_t          tb_evt;
  logic [CNT_W-1:0] cnt_nxt, ccr_act;
  logic             cmp_evt;

  oc_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .one_pulse (cfg_one_pulse),
    .trig      (trig_in),
    .dir       (cfg_dir),
    .psc       (cfg_psc),
    .reload    (cfg_reload),
    .running   (running),
    .cnt_cur   (count),
    .cnt_nxt   (cnt_nxt),
    .evt       (tb_evt)
  );

  oc_ccr_store #(.CNT_W(CNT_W)) u_ccr (
    .clk      (clk),
    .rst_n    (rst_n),
    .preload  (cfg_preload),
    .dma_en   (cfg_dma_en),
    .wrap     (tb_evt.ovf || tb_evt.udf),
    .cmp_evt  (cmp_evt),
    .sw_we    (sw_cmp_we),
    .sw_data  (sw_cmp_data),
    .in_valid (cmp_valid),
    .in_data  (cmp_data),
    .in_ready (cmp_ready),
    .ccr      (ccr_act)
  );

  oc_out_unit #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (tb_evt),
    .cnt_nxt  (cnt_nxt),
    .dir      (cfg_dir),
    .reload   (cfg_reload),
    .ccr      (ccr_act),
    .mode     (cfg_mode),
    .pol      (cfg_pol),
    .flag_clr (flag_clr),
    .cmp_evt  (cmp_evt),
    .flag     (cmp_flag),
    .pin      (oc_pin)
  );

endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_one_pulse,
  input logic             trig_in,
  input logic [2:0]       cfg_mode,
  input logic             cfg_pol,
  input logic             cfg_dma_en,
  input logic             flag_clr,
  input logic             cmp_valid,
  input logic             cmp_ready,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             cmp_flag,
  input logic             oc_pin
);

  // R1: a stopped counter does not move
  p_stopped_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(count));

  // R5: frozen mode keeps the pin unless polarity changes
  p_frozen_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b000) |=> (!$stable(cfg_pol) || $stable(oc_pin)));

  // R6: the flag stays set until a clear pulse
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !flag_clr) |=> cmp_flag);

  // R7: a pending request is held while no transfer happens
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ready && !cmp_valid && cfg_dma_en) |=> (cmp_ready || !cfg_dma_en));

  // R7: no request with reloading disabled
  p_req_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |=> !cmp_ready);

  // R9: an idle one-pulse timer stays idle without a trigger
  p_op_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_one_pulse && !running && !trig_in) |=> !running);

endmodule

bind oc_timer oc_timer_chk #(.CNT_W(CNT_W)) u_oc_timer_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_one_pulse (cfg_one_pulse),
  .trig_in       (trig_in),
  .cfg_mode      (cfg_mode),
  .cfg_pol       (cfg_pol),
  .cfg_dma_en    (cfg_dma_en),
  .flag_clr      (flag_clr),
  .cmp_valid     (cmp_valid),
  .cmp_ready     (cmp_ready),
  .count         (count),
  .running       (running),
  .cmp_flag      (cmp_flag),
  .oc_pin        (oc_pin)
);

// File: tb/oc_timer_bench.sv
module oc_timer_bench;

  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int PW    = 16;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          rst_n, cfg_enable, cfg_one_pulse, trig_in, cfg_pol, cfg_preload, cfg_dma_en;
  logic [1:0]    cfg_dir;
  logic [2:0]    cfg_mode;
  logic [PW-1:0] cfg_psc;
  logic [W-1:0]  cfg_reload, sw_cmp_data, cmp_data;
  logic          sw_cmp_we, flag_clr, cmp_valid;
  logic          cmp_ready, running, cmp_flag, oc_pin;
  logic [W-1:0]  count;

  oc_timer #(.CNT_W(W), .PSC_W(PW)) u_oc_timer (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_one_pulse(cfg_one_pulse),
    .trig_in(trig_in), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .cfg_preload(cfg_preload), .cfg_dma_en(cfg_dma_en), .cfg_psc(cfg_psc),
    .cfg_reload(cfg_reload), .sw_cmp_we(sw_cmp_we), .sw_cmp_data(sw_cmp_data),
    .flag_clr(flag_clr), .cmp_valid(cmp_valid), .cmp_data(cmp_data),
    .cmp_ready(cmp_ready), .count(count), .running(running), .cmp_flag(cmp_flag),
    .oc_pin(oc_pin)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected-state model
  logic [PW-1:0] m_div;
  logic [W-1:0]  m_cnt, m_act, m_pre;
  logic          m_run, m_trig, m_fall, m_flag, m_req, m_ref;

  // feeder and stimulus control
  logic [W-1:0] tbl [4];
  int  f_idx, f_delay, feed_max, toggles;
  bit  f_valid, f_junk, f_hs, junk_en, rnd_on, chk_on, last_pin;
  bit  pend_sw, pend_trig;
  logic [W-1:0] pend_val;

  task automatic model_step();
    logic [W-1:0] nc, wv, pre_n;
    logic nf, tick, ovf, udf, upd, evt, rise, hs, wr;
    tick = m_run && (m_div == cfg_psc);
    nc = m_cnt; nf = m_fall; ovf = 0; udf = 0;
    if (tick) begin
      if (cfg_dir == 2'b01) begin
        if (m_cnt == 0) begin nc = cfg_reload; udf = 1; end else nc = m_cnt - 1'b1;
      end else if (cfg_dir == 2'b10) begin
        if (!m_fall) begin
          if (m_cnt == cfg_reload) begin nc = cfg_reload - 1'b1; nf = 1; ovf = 1; end
          else nc = m_cnt + 1'b1;
        end else begin
          if (m_cnt == 0) begin nc = 1; nf = 0; udf = 1; end else nc = m_cnt - 1'b1;
        end
      end else begin
        if (m_cnt == cfg_reload) begin nc = 0; ovf = 1; end else nc = m_cnt + 1'b1;
      end
    end
    upd = ovf || udf;
    evt = tick && ((nc == m_act) ||
                   ((m_act > cfg_reload) && ((cfg_dir == 2'b10) ? ovf : upd)));
    rise = trig_in && !m_trig;
    hs = m_req && cmp_valid;
    wr = hs || sw_cmp_we;
    wv = hs ? cmp_data : sw_cmp_data;
    pre_n = wr ? wv : m_pre;
    case (cfg_mode)
      3'b011: m_ref = m_ref ^ evt;
      3'b110: m_ref = (nc < m_act);
      3'b111: m_ref = !(nc < m_act);
      default: ;
    endcase
    if (!cfg_preload && wr) m_act = wv;
    else if (cfg_preload && upd) m_act = pre_n;
    m_pre  = pre_n;
    m_req  = cfg_dma_en && (evt || (m_req && !hs));
    m_flag = evt ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    m_div  = (!m_run || tick) ? '0 : m_div + 1'b1;
    if (cfg_one_pulse) begin
      if (upd) m_run = 0; else if (rise) m_run = 1;
    end else m_run = cfg_enable;
    m_trig = trig_in;
    m_cnt  = nc;
    m_fall = nf;
  endtask

  task automatic drive();
    if (f_hs) begin f_idx = (f_idx + 1) % 4; f_valid = 0; end
    if (f_junk) begin f_valid = 0; f_junk = 0; end
    if (!f_valid) begin
      if (m_req) begin
        if (f_delay == 0) begin f_valid = 1; cmp_data = tbl[f_idx]; end
        else f_delay--;
      end else if (junk_en && $urandom_range(7) == 0) begin
        f_valid = 1; f_junk = 1; cmp_data = W'($urandom_range(40));
      end
    end
    cmp_valid = f_valid;
    f_hs = f_valid && m_req;
    if (f_hs) f_delay = $urandom_range(feed_max);
    sw_cmp_we = 0; flag_clr = 0; trig_in = 0;
    if (rnd_on) begin
      sw_cmp_we   = ($urandom_range(15) == 0);
      sw_cmp_data = W'($urandom_range(int'(cfg_reload) + 3));
      flag_clr    = ($urandom_range(7) == 0);
      trig_in     = ($urandom_range(9) == 0);
      if (!cfg_one_pulse) cfg_enable = ($urandom_range(49) != 0);
    end
    if (pend_sw) begin sw_cmp_we = 1; sw_cmp_data = pend_val; pend_sw = 0; end
    if (pend_trig) begin trig_in = 1; pend_trig = 0; end
    model_step();
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chk_on) begin
        chk("R1 R2 count", count, m_cnt);
        chk("R9 running", running, m_run);
        chk("R3 R4 R6 flag", cmp_flag, m_flag);
        chk("R7 request", cmp_ready, m_req);
        chk("R3 R5 R8 R10 pin", oc_pin, m_ref ^ cfg_pol);
      end
      if (oc_pin != last_pin) toggles++;
      last_pin = oc_pin;
      drive();
    end
  endtask

  task automatic restart();
    rst_n = 0; cmp_valid = 0; sw_cmp_we = 0; flag_clr = 0; trig_in = 0;
    m_div = 0; m_cnt = 0; m_act = 0; m_pre = 0; m_run = 0; m_trig = 0;
    m_fall = 0; m_flag = 0; m_req = 0; m_ref = 0;
    f_idx = 0; f_delay = 0; f_valid = 0; f_junk = 0; f_hs = 0;
    repeat (3) @(negedge clk);
    chk("reset count", count, 0);
    chk("reset flag", cmp_flag, 0);
    chk("reset request", cmp_ready, 0);
    chk("reset running", running, 0);
    rst_n = 1;
    last_pin = oc_pin;
    chk_on = 1;
    drive();
  endtask

  task automatic setup(input logic [1:0] dir, input logic [2:0] mode, input int psc,
                       input int rl, input bit dma, input bit pre, input bit op,
                       input logic [W-1:0] val);
    cfg_dir = dir; cfg_mode = mode; cfg_psc = PW'(psc); cfg_reload = W'(rl);
    cfg_dma_en = dma; cfg_preload = pre; cfg_one_pulse = op; cfg_pol = 0;
    cfg_enable = !op;
    for (int k = 0; k < 4; k++) tbl[k] = val;
    rnd_on = 0; junk_en = 0; feed_max = 2;
    pend_sw = 1; pend_val = val;
  endtask

  initial begin
    void'($urandom(32'd20241));
    chk_on = 0; pend_trig = 0;
    cfg_psc = '0; cfg_reload = '0; cmp_data = '0; sw_cmp_data = '0;
    cfg_dir = 0; cfg_mode = 0; cfg_pol = 0; cfg_preload = 0; cfg_dma_en = 0;
    cfg_one_pulse = 0; cfg_enable = 0;

    // R4: compare beyond the limit still fires once per period, each direction
    setup(2'b00, 3'b011, 0, 9, 1, 0, 0, 16'd20);
    restart(); step(25); toggles = 0; step(100);
    chk("R4 up beyond-limit toggles", toggles, 10);
    setup(2'b01, 3'b011, 0, 9, 1, 0, 0, 16'd20);
    restart(); step(25); toggles = 0; step(100);
    chk("R4 down beyond-limit toggles", toggles, 10);
    setup(2'b10, 3'b011, 0, 9, 1, 0, 0, 16'd20);
    restart(); step(30); toggles = 0; step(180);
    chk("R4 center beyond-limit toggles", toggles, 10);

    // R1 R3: prescaled period with an in-range compare
    setup(2'b00, 3'b011, 2, 4, 1, 0, 0, 16'd2);
    restart(); step(40); toggles = 0; step(150);
    chk("R1 R3 prescaled toggles", toggles, 10);

    // R9: one trigger gives exactly one period
    setup(2'b00, 3'b011, 0, 9, 0, 0, 1, 16'd3);
    restart(); step(5); pend_trig = 1; toggles = 0; step(40);
    chk("R9 one-pulse toggles", toggles, 1);
    chk("R9 one-pulse stopped", running, 0);

    // R8: a preloaded write is not used before the wrap
    setup(2'b00, 3'b011, 0, 9, 0, 1, 0, 16'd6);
    restart(); step(5);
    chk("R8 preload pin unchanged", oc_pin, 0);

    // mixed random segments
    for (int s = 0; s < 40; s++) begin
      logic [2:0] modes [4];
      int rl;
      modes[0] = 3'b000; modes[1] = 3'b011; modes[2] = 3'b110; modes[3] = 3'b111;
      rl = 2 + $urandom_range(10);
      setup(2'($urandom_range(2)), modes[$urandom_range(3)], $urandom_range(2), rl,
            $urandom_range(3) != 0, $urandom_range(1) == 1, $urandom_range(3) == 0,
            W'($urandom_range(rl + 3)));
      for (int k = 0; k < 4; k++) tbl[k] = W'($urandom_range(rl + 3));
      cfg_pol = 1'($urandom_range(1));
      rnd_on = 1; junk_en = 1; feed_max = 3;
      restart();
      step(300);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule